// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the host-side front end of a small peripheral that exposes a 128-byte space of registers and memory over an 8-bit multiplexed address/data bus. Each access begins with an address phase: the host drives an address on the shared lines and pulses the address strobe. A data phase follows under one of two strobe conventions, chosen by a strap input. In the level-qualified convention, a data strobe marks the data phase and a read/write level gives its direction. In the split-enable convention, an active-low read enable and an active-low write enable are used, in the style of a static RAM.

All bus inputs pass through a synchronizer into the system clock domain, where their edges are detected. The block keeps the latched address, makes the internal write strobe and read output enable, and sends the byte read back out through a separate output with an enable, which the pad ring combines into a bidirectional pin. Chip select, reset and a power-fail indication all gate the access. The storage behind the bus is a plain array in which some bits cannot be written. A read of the interrupt status register (address 0x0C) raises a one-cycle acknowledge toward the interrupt logic once the read window has closed.

Top module: `mbus_slave`

## Requirements
- R1: The low 7 bits of `ad_in` are captured as the address when `as_stb` falls. The data phase that follows reaches exactly that location.
- R2: A rising `as_stb` discards the captured address. No read or write takes place until `as_stb` falls again.
- R3: With `mode_ds` = 1, a fall of `ds_re` while `rw_we` is 0 writes `ad_in` into the addressed location.
- R4: With `mode_ds` = 1, `ad_oe` is high while `ds_re` and `rw_we` are both 1, and `ad_out` then carries the addressed byte. `ad_oe` drops when `ds_re` falls. Strobe effects appear two clock edges after a pin change.
- R5: With `mode_ds` = 0, a rise of `rw_we` (active-low write enable) writes `ad_in` into the addressed location.
- R6: With `mode_ds` = 0, `ad_oe` is high while `ds_re` (active-low read enable) is 0, with the addressed byte on `ad_out`. `ad_oe` drops when `ds_re` rises.
- R7: A data phase with `cs_n` high neither reads nor writes, and it uses up the captured address. A later data phase with `cs_n` low that has no new address strobe has no effect.
- R8: While `rst_n` is 0, `ad_oe` and `rd_ack` are 0 and no write takes effect. After reset every location reads 0.
- R9: While `pwr_fail` is 1, no write takes effect and `ad_oe` stays 0.
- R10: Writes to addresses 0x0C and 0x0D change nothing. Bit 7 of addresses 0x0A and 0x00 cannot be written and reads as 0.
- R11: `rd_ack` pulses for exactly one cycle, one cycle after `ad_oe` falls at the end of a read of address 0x0C. It does not pulse after a read of any other address.
- R12: `mode_ds` = 0 selects the split-enable convention, which is also the state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; holds off all access |
| pwr_fail | input | 1 | Power-fail indication; blocks access while high |
| mode_ds | input | 1 | 1: data strobe plus read/write level; 0: split read/write enables |
| cs_n | input | 1 | Active-low chip select |
| as_stb | input | 1 | Address strobe; address captured on its falling edge |
| ds_re | input | 1 | Data strobe (mode 1) or active-low read enable (mode 0) |
| rw_we | input | 1 | Read/write level (mode 1) or active-low write enable (mode 0) |
| ad_in | input | 8 | Multiplexed address/data lines, inbound |
| ad_out | output | 8 | Read data, valid while ad_oe is high |
| ad_oe | output | 1 | Output enable for the bidirectional lines |
| rd_ack | output | 1 | One-cycle pulse after a read of address 0x0C closes |

## Verification
The bench goes after the cases where the address is stale. A data phase with chip select inactive has to use up the address, so a design that kept it would let the next chip-selected strobe write the old location. A rising address strobe with no falling edge after it must void the address, and a design that missed this would accept a write while the strobe is still high. In the level-qualified mode, a write has to land only on the falling data strobe; a design that wrote on the rising edge, or drove the bus while the direction level was low, would corrupt the bytes read back. The bench also writes all ones to the protected bytes and bits, and it reads address 0x0C and other addresses to confirm that only the status read raises the acknowledge, for a single cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   // Strobe convention selected by the mode strap
   typedef enum logic {
      PROTO_EN = 1'b0,   // separate active-low read and write enables
      PROTO_DS = 1'b1    // data strobe qualified by a read/write level
   } proto_e;

   // Bit positions of the control lines inside the synchronized vector
   localparam int unsigned CTL_AS   = 0;
   localparam int unsigned CTL_DS   = 1;
   localparam int unsigned CTL_RW   = 2;
   localparam int unsigned CTL_CSN  = 3;
   localparam int unsigned CTL_PF   = 4;
   localparam int unsigned CTL_MODE = 5;
   localparam int unsigned CTL_W    = 6;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbus_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("mbus_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) chain[k] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < int'(STAGES); k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
   import mbus_pkg::*;
#(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ACK_ADDR = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTL_W-1:0]  ctl_s,
   input  logic [DATA_W-1:0] ad_s,
   output logic [ADDR_W-1:0] addr,
   output logic              addr_valid,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              oe,
   output logic              rd_ack
);

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("mbus_ctrl: the address must fit on the data lines");
      end
      if (ACK_ADDR >= (1 << ADDR_W)) begin : g_bad_ack
         $error("mbus_ctrl: ACK_ADDR outside the address space");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(ACK_ADDR);

   proto_e proto;
   logic as_s, ds_s, rw_s, csn_s, pf_s;
   logic as_p, ds_p, rw_p;
   logic as_fall, as_rise;
   logic wr_evt, rd_win, end_evt, granted;
   logic oe_q;

   assign proto = proto_e'(ctl_s[CTL_MODE]);
   assign as_s  = ctl_s[CTL_AS];
   assign ds_s  = ctl_s[CTL_DS];
   assign rw_s  = ctl_s[CTL_RW];
   assign csn_s = ctl_s[CTL_CSN];
   assign pf_s  = ctl_s[CTL_PF];

   // previous synchronized levels, for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_p <= 1'b0;
         ds_p <= 1'b0;
         rw_p <= 1'b1;
      end else begin
         as_p <= as_s;
         ds_p <= ds_s;
         rw_p <= rw_s;
      end
   end

   assign as_fall = as_p & ~as_s;
   assign as_rise = ~as_p & as_s;

   // per-convention meaning of the data-phase lines
   always_comb begin
      unique case (proto)
         PROTO_DS: begin
            wr_evt  = ds_p & ~ds_s & ~rw_s;
            rd_win  = ds_s & rw_s;
            end_evt = ds_p & ~ds_s;
         end
         default: begin
            wr_evt  = ~rw_p & rw_s;
            rd_win  = ~ds_s;
            end_evt = (~rw_p & rw_s) | (~ds_p & ds_s);
         end
      endcase
   end

   assign granted = addr_valid & ~csn_s & ~pf_s;
   assign wr_en   = granted & wr_evt;
   assign oe      = granted & rd_win;
   assign wr_data = ad_s;

   // address capture and consumption
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr       <= '0;
         addr_valid <= 1'b0;
      end else if (as_rise) begin
         addr_valid <= 1'b0;
      end else if (as_fall) begin
         addr       <= ad_s[ADDR_W-1:0];
         addr_valid <= 1'b1;
      end else if (end_evt) begin
         addr_valid <= 1'b0;
      end
   end

   // status-read acknowledge after the read window closes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= 1'b0;
         rd_ack <= 1'b0;
      end else begin
         oe_q   <= oe;
         rd_ack <= oe_q & ~oe & (addr == ACK_A);
      end
   end

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RO_FULL0 = 12,
   parameter int unsigned RO_FULL1 = 13,
   parameter int unsigned RO_BIT0  = 10,
   parameter int unsigned RO_BIT1  = 0,
   parameter int unsigned RO_POS   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (RO_POS >= DATA_W) begin : g_bad_pos
         $error("mbus_regfile: RO_POS outside the data width");
      end
      if (RO_FULL0 >= DEPTH || RO_FULL1 >= DEPTH ||
          RO_BIT0 >= DEPTH || RO_BIT1 >= DEPTH) begin : g_bad_ro
         $error("mbus_regfile: protected address outside the array");
      end
   endgenerate

   logic [DATA_W-1:0] cells [DEPTH];

   // bits a write is allowed to change at a given address
   function automatic logic [DATA_W-1:0] wmask(input logic [ADDR_W-1:0] a);
      logic [DATA_W-1:0] m;
      m = '1;
      if (a == ADDR_W'(RO_FULL0) || a == ADDR_W'(RO_FULL1))
         m = '0;
      else if (a == ADDR_W'(RO_BIT0) || a == ADDR_W'(RO_BIT1))
         m[RO_POS] = 1'b0;
      return m;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) cells[i] <= '0;
      end else if (wr_en) begin
         cells[addr] <= (cells[addr] & ~wmask(addr)) | (wr_data & wmask(addr));
      end
   end

   assign rd_data = cells[addr];

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
   import mbus_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAT_ADDR   = 12,
   parameter int unsigned FLAG_ADDR   = 13,
   parameter int unsigned CTRL_ADDR   = 10,
   parameter int unsigned SEC_ADDR    = 0,
   parameter int unsigned LOCK_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail,
   input  logic              mode_ds,
   input  logic              cs_n,
   input  logic              as_stb,
   input  logic              ds_re,
   input  logic              rw_we,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              rd_ack
);

   localparam int unsigned SYNC_W = CTL_W + DATA_W;
   localparam logic [CTL_W-1:0] CTL_IDLE =
      CTL_W'((1 << CTL_CSN) | (1 << CTL_RW));
   localparam logic [SYNC_W-1:0] SYNC_RST = {CTL_IDLE, {DATA_W{1'b0}}};

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("mbus_slave: DATA_W too small");
      end
      if (ADDR_W < 4) begin : g_bad_addrw
         $error("mbus_slave: ADDR_W too small for the register block");
      end
   endgenerate

   logic [CTL_W-1:0]  ctl_raw, ctl_s;
   logic [DATA_W-1:0] ad_s;
   logic [ADDR_W-1:0] addr;
   logic              addr_valid;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic              cs_n_s, pf_s;

   always_comb begin
      ctl_raw           = '0;
      ctl_raw[CTL_AS]   = as_stb;
      ctl_raw[CTL_DS]   = ds_re;
      ctl_raw[CTL_RW]   = rw_we;
      ctl_raw[CTL_CSN]  = cs_n;
      ctl_raw[CTL_PF]   = pwr_fail;
      ctl_raw[CTL_MODE] = mode_ds;
   end

   mbus_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ctl_raw, ad_in}),
      .q     ({ctl_s, ad_s})
   );

   assign cs_n_s = ctl_s[CTL_CSN];
   assign pf_s   = ctl_s[CTL_PF];

   mbus_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ACK_ADDR (STAT_ADDR)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_s      (ctl_s),
      .ad_s       (ad_s),
      .addr       (addr),
      .addr_valid (addr_valid),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .oe         (ad_oe),
      .rd_ack     (rd_ack)
   );

   mbus_regfile #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RO_FULL0 (STAT_ADDR),
      .RO_FULL1 (FLAG_ADDR),
      .RO_BIT0  (CTRL_ADDR),
      .RO_BIT1  (SEC_ADDR),
      .RO_POS   (LOCK_BIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   assign ad_out = ad_oe ? rd_data : '0;

endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic ad_oe,
   input logic rd_ack,
   input logic wr_en,
   input logic addr_valid,
   input logic cs_n_s,
   input logic pf_s
);

   a_r9_pf_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
      pf_s |-> !ad_oe);

   a_r9_pf_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      pf_s |-> !wr_en);

   a_r7_deselect_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |-> !wr_en);

   a_r2_drive_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> addr_valid);

   a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |=> !rd_ack);

   a_r11_ack_after_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |-> ($past(ad_oe, 2) && !$past(ad_oe)));

endmodule

bind mbus_slave mbus_slave_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ad_oe      (ad_oe),
   .rd_ack     (rd_ack),
   .wr_en      (wr_en),
   .addr_valid (addr_valid),
   .cs_n_s     (cs_n_s),
   .pf_s       (pf_s)
);

// File: tb/mbus_slave_bench.sv
module mbus_slave_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_fail = 1'b0;
   logic       mode_ds = 1'b0;
   logic       cs_n = 1'b1;
   logic       as_stb = 1'b0;
   logic       ds_re = 1'b0;
   logic       rw_we = 1'b1;
   logic [7:0] ad_in = 8'h00;
   logic [7:0] ad_out;
   logic       ad_oe;
   logic       rd_ack;

   int n_vec = 0;
   int n_bad = 0;
   int ack_seen = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mbus_slave u_mbus_slave (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .mode_ds(mode_ds),
      .cs_n(cs_n), .as_stb(as_stb), .ds_re(ds_re), .rw_we(rw_we),
      .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .rd_ack(rd_ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   // pin snapshot: [7:0] ad, 8 as, 9 ds, 10 rw, 11 cs_n, 12 pwr_fail, 13 mode
   localparam logic [13:0] IDLE = 14'b00_1_1_0_0_00000000;
   logic [13:0] h0 = IDLE, h1 = IDLE, h2 = IDLE;
   logic [7:0]  m_mem [128];
   int          m_addr = 0;
   bit          m_valid = 0, m_oe_q = 0, m_ack = 0;

   function automatic bit oe_of(logic [13:0] c, bit valid);
      bit win;
      win = c[13] ? (c[9] && c[10]) : !c[9];
      return valid && !c[11] && !c[12] && win;
   endfunction

   function automatic logic [7:0] keep_mask(int a);
      if (a == 12 || a == 13) return 8'h00;
      if (a == 10 || a == 0) return 8'h7f;
      return 8'hff;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h0 = IDLE; h1 = IDLE; h2 = IDLE;
         for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
         m_addr = 0; m_valid = 0; m_oe_q = 0; m_ack = 0;
      end else begin
         bit wr, fin, oe_now, go;
         go = m_valid && !h1[11] && !h1[12];
         if (h1[13]) begin
            wr  = h2[9] && !h1[9] && !h1[10];
            fin = h2[9] && !h1[9];
         end else begin
            wr  = !h2[10] && h1[10];
            fin = (!h2[10] && h1[10]) || (!h2[9] && h1[9]);
         end
         oe_now = oe_of(h1, m_valid);
         m_ack  = m_oe_q && !oe_now && (m_addr == 12);
         m_oe_q = oe_now;
         if (go && wr)
            m_mem[m_addr] = (m_mem[m_addr] & ~keep_mask(m_addr)) | (h1[7:0] & keep_mask(m_addr));
         if (!h2[8] && h1[8]) m_valid = 0;
         else if (h2[8] && !h1[8]) begin m_valid = 1; m_addr = int'(h1[6:0]); end
         else if (fin) m_valid = 0;
         h2 = h1; h1 = h0;
         h0 = {mode_ds, pwr_fail, cs_n, rw_we, ds_re, as_stb, ad_in};
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      bit eo;
      eo = oe_of(h1, m_valid);
      chk("R4 R6 R8 model ad_oe", 32'(ad_oe), 32'(eo));
      if (eo) chk("R1 R3 R5 model ad_out", 32'(ad_out), 32'(m_mem[m_addr]));
      chk("R11 model rd_ack", 32'(rd_ack), 32'(m_ack));
      if (rd_ack) ack_seen++;
   end

   // ---------------- stimulus helpers ----------------
   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic addr_phase(input logic [6:0] a);
      ad_in = {1'b0, a}; as_stb = 1'b1; wt(3);
      as_stb = 1'b0; wt(3);
   endtask

   task automatic ds_wr(input logic [6:0] a, input logic [7:0] d, input bit sel);
      addr_phase(a);
      cs_n = !sel; rw_we = 1'b0; ad_in = d; wt(3);
      ds_re = 1'b1; wt(3);
      ds_re = 1'b0; wt(3);
      rw_we = 1'b1; cs_n = 1'b1; wt(2);
   endtask

   task automatic ds_rd(input logic [6:0] a, input bit drive, input logic [7:0] d, input string tag);
      addr_phase(a);
      cs_n = 1'b0; rw_we = 1'b1; ds_re = 1'b1; wt(3);
      chk({tag, " oe"}, 32'(ad_oe), 32'(drive));
      if (drive) chk({tag, " data"}, 32'(ad_out), 32'(d));
      ds_re = 1'b0; wt(3);
      chk({tag, " release"}, 32'(ad_oe), 32'd0);
      cs_n = 1'b1; wt(2);
   endtask

   task automatic en_wr(input logic [6:0] a, input logic [7:0] d, input bit sel);
      addr_phase(a);
      cs_n = !sel; ad_in = d; rw_we = 1'b0; wt(3);
      rw_we = 1'b1; wt(3);
      cs_n = 1'b1; wt(2);
   endtask

   task automatic en_rd(input logic [6:0] a, input bit drive, input logic [7:0] d, input string tag);
      addr_phase(a);
      cs_n = 1'b0; ds_re = 1'b0; wt(3);
      chk({tag, " oe"}, 32'(ad_oe), 32'(drive));
      if (drive) chk({tag, " data"}, 32'(ad_out), 32'(d));
      ds_re = 1'b1; wt(3);
      chk({tag, " release"}, 32'(ad_oe), 32'd0);
      cs_n = 1'b1; wt(2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int a0;
      wt(3);
      chk("R8 reset ad_oe", 32'(ad_oe), 32'd0);
      chk("R8 reset rd_ack", 32'(rd_ack), 32'd0);
      rst_n = 1'b1; wt(4);
      chk("R12 default mode enable-read", 32'(ad_oe), 32'd0);

      // level-qualified convention
      mode_ds = 1'b1; ds_re = 1'b0; rw_we = 1'b1; wt(4);
      ds_rd(7'h05, 1'b1, 8'h00, "R8 cleared after reset");
      ds_wr(7'h05, 8'h5a, 1'b1);
      ds_rd(7'h05, 1'b1, 8'h5a, "R3 R4 write then read");
      ds_wr(7'h20, 8'hc3, 1'b1);
      ds_rd(7'h05, 1'b1, 8'h5a, "R1 other address untouched");
      ds_rd(7'h20, 1'b1, 8'hc3, "R1 second address");

      // read-only locations and bits
      ds_wr(7'h0c, 8'hff, 1'b1);
      ds_rd(7'h0c, 1'b1, 8'h00, "R10 status byte protected");
      ds_wr(7'h0d, 8'hff, 1'b1);
      ds_rd(7'h0d, 1'b1, 8'h00, "R10 flag byte protected");
      ds_wr(7'h0a, 8'hff, 1'b1);
      ds_rd(7'h0a, 1'b1, 8'h7f, "R10 control bit 7 protected");
      ds_wr(7'h00, 8'hff, 1'b1);
      ds_rd(7'h00, 1'b1, 8'h7f, "R10 seconds bit 7 protected");

      // status acknowledge
      a0 = ack_seen;
      ds_rd(7'h0c, 1'b1, 8'h00, "R11 status read");
      chk("R11 one ack after status read", 32'(ack_seen - a0), 32'd1);
      a0 = ack_seen;
      ds_rd(7'h05, 1'b1, 8'h5a, "R11 plain read");
      chk("R11 no ack after other read", 32'(ack_seen - a0), 32'd0);

      // deselected cycle consumes the address
      ds_wr(7'h05, 8'h11, 1'b0);
      cs_n = 1'b0; rw_we = 1'b0; ad_in = 8'h22; wt(3);
      ds_re = 1'b1; wt(3); ds_re = 1'b0; wt(3);
      rw_we = 1'b1; cs_n = 1'b1; wt(2);
      ds_rd(7'h05, 1'b1, 8'h5a, "R7 stale address ignored");

      // rising address strobe voids the address
      addr_phase(7'h05);
      as_stb = 1'b1; wt(3);
      cs_n = 1'b0; rw_we = 1'b0; ad_in = 8'h33; wt(3);
      ds_re = 1'b1; wt(3); ds_re = 1'b0; wt(3);
      rw_we = 1'b1; cs_n = 1'b1; wt(2);
      ds_rd(7'h05, 1'b1, 8'h5a, "R2 write after strobe rise ignored");

      // power-fail lockout
      pwr_fail = 1'b1; wt(3);
      ds_wr(7'h05, 8'h44, 1'b1);
      ds_rd(7'h05, 1'b0, 8'h00, "R9 no drive in power fail");
      pwr_fail = 1'b0; wt(3);
      ds_rd(7'h05, 1'b1, 8'h5a, "R9 write blocked in power fail");

      // split-enable convention
      mode_ds = 1'b0; ds_re = 1'b1; rw_we = 1'b1; wt(4);
      en_wr(7'h30, 8'h96, 1'b1);
      en_rd(7'h30, 1'b1, 8'h96, "R5 R6 R12 enable write then read");
      en_wr(7'h31, 8'h3c, 1'b1);
      en_rd(7'h31, 1'b1, 8'h3c, "R5 R6 second location");
      en_wr(7'h30, 8'h00, 1'b0);
      en_rd(7'h30, 1'b1, 8'h96, "R7 deselected enable write");
      a0 = ack_seen;
      en_rd(7'h0c, 1'b1, 8'h00, "R11 status read enable mode");
      chk("R11 ack in enable mode", 32'(ack_seen - a0), 32'd1);

      // reset lockout mid-run
      addr_phase(7'h30);
      cs_n = 1'b0; rst_n = 1'b0; ds_re = 1'b0; wt(4);
      chk("R8 no drive during reset", 32'(ad_oe), 32'd0);
      ds_re = 1'b1; cs_n = 1'b1; wt(2);
      rst_n = 1'b1; wt(4);
      en_rd(7'h30, 1'b1, 8'h00, "R8 contents cleared");

      wt(4);
      finish_run();
   end

endmodule